// File: doc/BRIEF.md
# PCI I/O Target with Byte-Window Abort

This block is the I/O-space target of a 32-bit PCI interface. At the start of a transaction it compares the full byte address with a window. The window has a base aligned to `WIN_BYTES` and a programmable length in bytes. It claims only the two I/O command codes. In the first data phase, each byte lane selected by the active-low byte enables is mapped to its byte offset in the window. Any selected byte that falls outside the window causes the whole access to be refused with a target-abort, and no data moves.

When every selected byte is valid, the block makes one request on a simple local register port: a byte offset, active-high byte strobes, a write flag and write data. It waits for the register side to acknowledge. It then completes a single data phase with TRDY. If the initiator still holds FRAME at that point, the block disconnects with STOP. Bursts, memory space, configuration space and parity belong to other blocks.

The local side reads the window offset from `reg_addr` and serves one request at a time.

Top module: `pci_io_range_target`

## Requirements
- R1: While reset is asserted, and after its release until a cycle is claimed, `devsel_n`, `trdy_n` and `stop_n` are high and `tgt_oe`, `ad_oe` and `reg_req` are low.
- R2: An address phase is the first cycle with `frame_n` low after a cycle with it high. If it carries command 4'b0010 (I/O read) or 4'b0011 (I/O write) on `cbe_n`, and a byte address A with `win_base` <= A < `win_base` + `win_len`, then `devsel_n` is low in the following cycle.
- R3: Any other command code, or an address outside the window, is not claimed: `devsel_n` stays high and `reg_req` stays low.
- R4: A legal access raises `reg_req` in the cycle after the first data-phase cycle with `irdy_n` low. It presents `reg_addr` = A - `win_base` (including A[1:0]), `reg_be` = ~`cbe_n`, `reg_we` = command bit 0, and `reg_wdata` = the AD value of that cycle. All of these are held until `reg_ack` is sampled high.
- R5: In the cycle after `reg_ack` is sampled high during a request, `trdy_n` is low for exactly one cycle. For a read, the same cycle also has `ad_oe` high and `ad_out` equal to the `reg_rdata` sampled with the acknowledge.
- R6: If a selected lane L of the dword at A has a byte offset ((A - `win_base`) with bits 1:0 replaced by L) of `win_len` or more, the access is target-aborted. This means `devsel_n` high, `stop_n` low and `trdy_n` high, with no register request.
- R7: If a selected lane L lies below A[1:0], the byte enables contradict the address and the access is target-aborted in the same way. A lane equal to or above A[1:0] is accepted.
- R8: If `frame_n` is still low when the completion cycle is entered, `stop_n` is low together with `trdy_n`. Afterwards `stop_n` and `devsel_n` stay low until `frame_n` is sampled high.
- R9: A data phase with no lane selected (`cbe_n` = 4'b1111) completes with `trdy_n` low in the next cycle and makes no register request.
- R10: A target-abort is held while `frame_n` stays low. After `frame_n` is sampled high, all outputs are released and a new address phase is claimed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_base | input | 32 | Window base byte address, aligned to WIN_BYTES |
| win_len | input | $clog2(WIN_BYTES)+1 | Number of valid bytes in the window, 0 to WIN_BYTES |
| frame_n | input | 1 | Initiator transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases, active low |
| ad_in | input | 32 | Address/data bus as received |
| ad_out | output | 32 | Read data for the bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| tgt_oe | output | 1 | Drive enable for devsel_n, trdy_n and stop_n |
| reg_req | output | 1 | Register port request |
| reg_we | output | 1 | Register port write flag |
| reg_addr | output | $clog2(WIN_BYTES) | Byte offset within the window |
| reg_be | output | 4 | Active-high byte strobes |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data from the register side |
| reg_ack | input | 1 | Register side acknowledge |

## Verification
The claim appears one cycle after the address phase. The abort, the register request, or the direct completion for an empty lane set appears one cycle after the first data-phase cycle with IRDY low. TRDY falls one cycle after the acknowledge is sampled, and the disconnect STOP is released one cycle after FRAME is seen high. The bench drives every input on the falling clock edge and reads results on a later falling edge, counting exactly that many rising edges with a single step task. Delayed acknowledges and held FRAME stretch the sequence by whole cycles, so each check still lands on the cycle the requirement names.

// File: rtl/pci_iot_pkg.sv
package pci_iot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ACCESS,
    ST_COMPLETE,
    ST_ABORT,
    ST_HOLD
  } iot_state_e;

  localparam logic [3:0] CMD_IO_RD = 4'b0010;
  localparam logic [3:0] CMD_IO_WR = 4'b0011;

  localparam int unsigned LANES = 4;

endpackage

// File: rtl/pci_iot_rst_sync.sv
module pci_iot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pci_iot_decode.sv
module pci_iot_decode #(
  parameter int unsigned OFF_W = 4,
  parameter int unsigned LEN_W = OFF_W + 1
) (
  input  logic [31:0]      ad_in,
  input  logic [3:0]       cbe_n,
  input  logic [31:0]      win_base,
  input  logic [LEN_W-1:0] win_len,
  output logic             hit,
  output logic             is_write,
  output logic [OFF_W-1:0] off
);
  import pci_iot_pkg::*;

  logic [31:0] delta;
  logic        cmd_io;
  logic        in_block;
  logic        in_len;

  always_comb begin
    delta    = ad_in - win_base;
    cmd_io   = (cbe_n == CMD_IO_RD) || (cbe_n == CMD_IO_WR);
    in_block = (delta[31:OFF_W] == '0);
    in_len   = ({1'b0, delta[OFF_W-1:0]} < win_len);
    hit      = cmd_io && in_block && in_len;
    is_write = cbe_n[0];
    off      = delta[OFF_W-1:0];
  end

endmodule

// File: rtl/pci_iot_lanes.sv
module pci_iot_lanes #(
  parameter int unsigned OFF_W = 4,
  parameter int unsigned LEN_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off_q,
  input  logic [LEN_W-1:0] win_len,
  input  logic [3:0]       cbe_n,
  output logic [3:0]       be,
  output logic             lanes_ok,
  output logic             any_lane
);
  import pci_iot_pkg::*;

  logic [LEN_W-1:0] dw_base;
  logic [LANES-1:0] lane_bad;

  assign dw_base = {1'b0, off_q} & ~LEN_W'(3);
  assign be      = ~cbe_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LEN_W-1:0] lane_off;
    logic             past_end;
    logic             below_lo;
    assign lane_off    = dw_base | LEN_W'(g);
    assign past_end    = (lane_off >= win_len);
    assign below_lo    = (2'(g) < off_q[1:0]);
    assign lane_bad[g] = be[g] && (past_end || below_lo);
  end

  assign lanes_ok = ~|lane_bad;
  assign any_lane = |be;

endmodule

// File: rtl/pci_iot_fsm.sv
module pci_iot_fsm (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic hit,
  input  logic lanes_ok,
  input  logic any_lane,
  input  logic reg_ack,
  output logic addr_ld,
  output logic data_ld,
  output logic rdata_ld,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic tgt_oe,
  output logic reg_req,
  output logic in_complete
);
  import pci_iot_pkg::*;

  iot_state_e state_q, state_d;
  logic       frame_q, frame_d;
  logic       disc_q, disc_d;
  logic       enter_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (frame_q && !frame_n && hit) state_d = ST_CHECK;
      ST_CHECK:    if (!irdy_n) begin
                     if (!lanes_ok)     state_d = ST_ABORT;
                     else if (any_lane) state_d = ST_ACCESS;
                     else               state_d = ST_COMPLETE;
                   end
      ST_ACCESS:   if (reg_ack) state_d = ST_COMPLETE;
      ST_COMPLETE: state_d = frame_n ? ST_IDLE : ST_HOLD;
      ST_ABORT:    if (frame_n) state_d = ST_IDLE;
      ST_HOLD:     if (frame_n) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    enter_done = (state_d == ST_COMPLETE) && (state_q != ST_COMPLETE);
    disc_d     = enter_done ? !frame_n : disc_q;
    frame_d    = frame_n;
    addr_ld    = (state_q == ST_IDLE)   && (state_d == ST_CHECK);
    data_ld    = (state_q == ST_CHECK)  && !irdy_n;
    rdata_ld   = (state_q == ST_ACCESS) && reg_ack;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
      disc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      disc_q  <= disc_d;
    end
  end

  always_comb begin
    devsel_n    = !((state_q == ST_CHECK) || (state_q == ST_ACCESS) ||
                    (state_q == ST_COMPLETE) || (state_q == ST_HOLD));
    trdy_n      = (state_q != ST_COMPLETE);
    stop_n      = !((state_q == ST_ABORT) || (state_q == ST_HOLD) ||
                    ((state_q == ST_COMPLETE) && disc_q));
    tgt_oe      = (state_q != ST_IDLE);
    reg_req     = (state_q == ST_ACCESS);
    in_complete = (state_q == ST_COMPLETE);
  end

endmodule

// File: rtl/pci_io_range_target.sv
module pci_io_range_target #(
  parameter int unsigned WIN_BYTES = 16,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
  localparam int unsigned LEN_W    = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      win_base,
  input  logic [LEN_W-1:0] win_len,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [3:0]       cbe_n,
  input  logic [31:0]      ad_in,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             tgt_oe,
  output logic             reg_req,
  output logic             reg_we,
  output logic [OFF_W-1:0] reg_addr,
  output logic [3:0]       reg_be,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata,
  input  logic             reg_ack
);

  logic             rst_sync_n;
  logic             hit, is_write;
  logic [OFF_W-1:0] off_dec;
  logic [3:0]       be_lane;
  logic             lanes_ok, any_lane;
  logic             addr_ld, data_ld, rdata_ld, in_complete;

  logic [OFF_W-1:0] off_q, off_d;
  logic             we_q, we_d;
  logic [3:0]       be_q, be_d;
  logic [31:0]      wdata_q, wdata_d;
  logic [31:0]      rdata_q, rdata_d;

  pci_iot_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pci_iot_decode #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_dec (
    .ad_in    (ad_in),
    .cbe_n    (cbe_n),
    .win_base (win_base),
    .win_len  (win_len),
    .hit      (hit),
    .is_write (is_write),
    .off      (off_dec)
  );

  pci_iot_lanes #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_lanes (
    .off_q    (off_q),
    .win_len  (win_len),
    .cbe_n    (cbe_n),
    .be       (be_lane),
    .lanes_ok (lanes_ok),
    .any_lane (any_lane)
  );

  pci_iot_fsm u_fsm (
    .clk         (clk),
    .rst_sync_n  (rst_sync_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .hit         (hit),
    .lanes_ok    (lanes_ok),
    .any_lane    (any_lane),
    .reg_ack     (reg_ack),
    .addr_ld     (addr_ld),
    .data_ld     (data_ld),
    .rdata_ld    (rdata_ld),
    .devsel_n    (devsel_n),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .tgt_oe      (tgt_oe),
    .reg_req     (reg_req),
    .in_complete (in_complete)
  );

  always_comb begin
    off_d   = addr_ld  ? off_dec  : off_q;
    we_d    = addr_ld  ? is_write : we_q;
    be_d    = data_ld  ? be_lane  : be_q;
    wdata_d = data_ld  ? ad_in    : wdata_q;
    rdata_d = rdata_ld ? reg_rdata : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      off_q   <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      off_q   <= off_d;
      we_q    <= we_d;
      be_q    <= be_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_we    = we_q;
  assign reg_addr  = off_q;
  assign reg_be    = be_q;
  assign reg_wdata = wdata_q;
  assign ad_out    = rdata_q;
  assign ad_oe     = in_complete && !we_q;

endmodule

// File: rtl/pci_io_range_target_chk.sv
module pci_io_range_target_chk #(
  parameter int unsigned OFF_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic             devsel_n,
  input logic             trdy_n,
  input logic             stop_n,
  input logic             ad_oe,
  input logic             reg_req,
  input logic             reg_ack,
  input logic             reg_we,
  input logic [OFF_W-1:0] reg_addr,
  input logic [3:0]       reg_be
);

  p_claim_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n));

  p_req_claimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !devsel_n);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_be) && $stable(reg_we)));

  p_ack_to_trdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack) |=> !trdy_n);

  p_trdy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |=> trdy_n);

  p_trdy_with_devsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  p_abort_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_n && !stop_n) |-> (trdy_n && !reg_req && !ad_oe));

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);

endmodule

bind pci_io_range_target pci_io_range_target_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/pci_io_range_target_test.sv
module pci_io_range_target_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WIN = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] win_base;
  logic [4:0]  win_len;
  logic        frame_n, irdy_n;
  logic [3:0]  cbe_n;
  logic [31:0] ad_in;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n, tgt_oe;
  logic        reg_req, reg_we;
  logic [3:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_ack;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_io_range_target #(.WIN_BYTES(WIN)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0; reg_ack = 1'b0;
    step();
  endtask

  task automatic addr_phase(input logic [31:0] a, input logic [3:0] c);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = c;
    step();
  endtask

  task automatic data_phase(input logic [31:0] d, input logic [3:0] ben, input logic last);
    ad_in = d; cbe_n = ben; irdy_n = 1'b0; frame_n = last;
    step();
  endtask

  task automatic t_reset();
    chk("R1 devsel_n in reset", devsel_n, 1);
    chk("R1 trdy_n in reset",   trdy_n, 1);
    chk("R1 stop_n in reset",   stop_n, 1);
    chk("R1 enables in reset",  {tgt_oe, ad_oe, reg_req}, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 idle after release", {devsel_n, trdy_n, stop_n, tgt_oe, reg_req}, 5'b11100);
  endtask

  task automatic t_read_ok();
    addr_phase(32'h0000_1204, 4'b0010);
    chk("R2 claim read", devsel_n, 0);
    chk("R2 no trdy at claim", trdy_n, 1);
    reg_rdata = 32'hCAFE_F00D; reg_ack = 1'b1;
    data_phase(32'h0, 4'b0000, 1'b1);
    chk("R4 read req", {reg_req, reg_we}, 2'b10);
    chk("R4 read offset", reg_addr, 4);
    chk("R4 read strobes", reg_be, 4'hF);
    step();
    chk("R5 read trdy", {trdy_n, stop_n, ad_oe, reg_req}, 4'b0110);
    chk("R5 read data", ad_out, 32'hCAFE_F00D);
    reg_ack = 1'b0;
    step();
    chk("R5 trdy single cycle", {trdy_n, devsel_n}, 2'b11);
    bus_idle();
  endtask

  task automatic t_write_wait();
    addr_phase(32'h0000_1208, 4'b0011);
    chk("R2 claim write", devsel_n, 0);
    data_phase(32'h1234_5678, 4'b1100, 1'b1);
    chk("R4 write req", {reg_req, reg_we}, 2'b11);
    chk("R4 write offset", reg_addr, 8);
    chk("R4 write strobes", reg_be, 4'h3);
    chk("R4 write data", reg_wdata, 32'h1234_5678);
    step();
    chk("R4 req held without ack", {reg_req, trdy_n, reg_addr}, {2'b11, 4'd8});
    reg_ack = 1'b1;
    step();
    chk("R5 write trdy after ack", {trdy_n, ad_oe, reg_req}, 3'b000);
    reg_ack = 1'b0;
    step();
    chk("R5 write trdy released", trdy_n, 1);
    bus_idle();
  endtask

  task automatic t_range();
    addr_phase(32'h0000_1208, 4'b0010);
    data_phase(32'h0, 4'b0000, 1'b1);
    chk("R6 abort past window", {devsel_n, stop_n, trdy_n, reg_req}, 4'b1010);
    step();
    chk("R6 released after abort", {stop_n, tgt_oe, reg_req}, 3'b100);
    bus_idle();
    addr_phase(32'h0000_1209, 4'b0010);
    reg_rdata = 32'h0000_5A00; reg_ack = 1'b1;
    data_phase(32'h0, 4'b1101, 1'b1);
    chk("R6 last valid byte accepted", {reg_req, reg_addr, reg_be}, {1'b1, 4'd9, 4'h2});
    step();
    chk("R6 last byte completes", {trdy_n, stop_n}, 2'b01);
    bus_idle();
  endtask

  task automatic t_below();
    addr_phase(32'h0000_1202, 4'b0011);
    data_phase(32'h0, 4'b1110, 1'b1);
    chk("R7 lane below AD[1:0] aborts", {devsel_n, stop_n, trdy_n, reg_req}, 4'b1010);
    bus_idle();
    addr_phase(32'h0000_1203, 4'b0011);
    reg_ack = 1'b1;
    data_phase(32'hAB00_0000, 4'b0111, 1'b1);
    chk("R7 lane at AD[1:0] accepted", {reg_req, reg_addr, reg_be}, {1'b1, 4'd3, 4'h8});
    step();
    chk("R7 byte write completes", trdy_n, 0);
    bus_idle();
  endtask

  task automatic t_no_claim();
    logic [35:0] cases [3];
    cases[0] = {4'b0110, 32'h0000_1204};
    cases[1] = {4'b0010, 32'h0000_120A};
    cases[2] = {4'b0010, 32'h0000_1304};
    for (int i = 0; i < 3; i++) begin
      addr_phase(cases[i][31:0], cases[i][35:32]);
      chk("R3 not claimed", {devsel_n, tgt_oe}, 2'b10);
      data_phase(32'h0, 4'b0000, 1'b1);
      chk("R3 no request", {devsel_n, reg_req, trdy_n, stop_n}, 4'b1011);
      bus_idle();
    end
  endtask

  task automatic t_empty();
    addr_phase(32'h0000_1200, 4'b0011);
    data_phase(32'h0, 4'b1111, 1'b1);
    chk("R9 empty lanes complete", {trdy_n, devsel_n, reg_req}, 3'b000);
    step();
    chk("R9 empty done", trdy_n, 1);
    bus_idle();
  endtask

  task automatic t_disconnect();
    addr_phase(32'h0000_1200, 4'b0010);
    reg_rdata = 32'h0BAD_BEEF; reg_ack = 1'b1;
    data_phase(32'h0, 4'b0000, 1'b0);
    chk("R4 request before disconnect", reg_req, 1);
    step();
    chk("R8 trdy with stop", {trdy_n, stop_n}, 2'b00);
    chk("R8 disconnect data", ad_out, 32'h0BAD_BEEF);
    step();
    chk("R8 stop held while frame low", {stop_n, trdy_n, devsel_n}, 3'b010);
    frame_n = 1'b1;
    step();
    chk("R8 stop released", {stop_n, devsel_n}, 2'b11);
    bus_idle();
  endtask

  task automatic t_abort_hold();
    addr_phase(32'h0000_1208, 4'b0010);
    data_phase(32'h0, 4'b0000, 1'b0);
    chk("R10 abort entered", {devsel_n, stop_n}, 2'b10);
    step();
    chk("R10 abort held", {devsel_n, stop_n, trdy_n}, 3'b101);
    frame_n = 1'b1;
    step();
    chk("R10 abort released", {stop_n, tgt_oe}, 2'b10);
    bus_idle();
    addr_phase(32'h0000_1200, 4'b0010);
    chk("R10 claim after abort", devsel_n, 0);
    reg_ack = 1'b1;
    data_phase(32'h0, 4'b1110, 1'b1);
    step();
    chk("R10 completes after abort", trdy_n, 0);
    bus_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    win_base = 32'h0000_1200; win_len = 5'd10;
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
    reg_rdata = '0; reg_ack = 1'b0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    step();
    t_reset();
    t_read_ok();
    t_write_wait();
    t_range();
    t_below();
    t_no_claim();
    t_empty();
    t_disconnect();
    t_abort_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule